// File: doc/BRIEF.md
# Status Word and Dual Interrupt Line Controller

This block keeps the status word of a card host controller and produces two interrupt outputs from it. Eleven event bits are sticky. A one-cycle pulse from the command engine, the data engine or the FIFO sets an event bit, and the bit stays set until software writes a one to the matching position of a clear register. Eleven further bits are live level bits. These show current bus activity and FIFO fill conditions, and they are never stored.

Two mask registers share the bit layout of the status word. Each mask selects the status bits that can raise its own interrupt line. The main line is meant for errors and completion events. The auxiliary line is meant for FIFO servicing conditions, such as receive half-full, receive data available and transmit half-empty.

Software reaches everything through a simple register port. A write takes effect on the clock edge. Read data is a combinational decode of the address.

Top module: `sirq_status_ctrl`

## Requirements
- R1: After reset, all sticky bits and both mask registers are zero. With the level inputs low, status reads 0 and both interrupt lines are low.
- R2: A high level on `evt_set_i[k]` for one cycle sets status bit k from the next cycle on, and the bit stays set after the pulse ends. Event bit order from 0 to 10: command CRC fail, data CRC fail, command timeout, data timeout, transmit underrun, receive overrun, response end, command sent, data end, start-bit error, data block end.
- R3: A write to offset 0x38 clears every sticky bit whose `reg_wdata` bit (0..10) is one, from the next cycle on. Sticky bits with a zero in the write data keep their value.
- R4: If a set pulse and a clear write hit the same sticky bit in the same cycle, the bit is set in the next cycle.
- R5: Status bits 11..21 equal `lvl_i[0..10]` in the same cycle. Level bit order from bit 11 to bit 21: command active, transmit active, receive active, transmit FIFO half empty, receive FIFO half full, transmit FIFO full, receive FIFO full, transmit FIFO empty, receive FIFO empty, transmit data available, receive data available. A clear write has no effect on these bits.
- R6: Offsets 0x3C (main mask) and 0x40 (auxiliary mask) can be written and read back. Only bits 21..0 are stored, and bits 31..22 read as zero.
- R7: `irq_main_o` is the OR over all bits of (status AND main mask), and `irq_aux_o` is the same for the auxiliary mask. Both are combinational from the current status.
- R8: Status at offset 0x34 is read-only, so a write to it changes nothing. Offset 0x38 and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| evt_set_i | input | 11 | Sticky event set pulses |
| lvl_i | input | 11 | Live level conditions |
| irq_main_o | output | 1 | Main interrupt line |
| irq_aux_o | output | 1 | Auxiliary interrupt line |

## Verification
The bench goes after the cycle in which a set pulse and a clear write collide on the same bit. A design that lets the clear win would lose that event, and the bit would read zero. It also issues clear writes with every bit set while level inputs are high. A design that stored the level bits, or masked them with the clear data, would show a stale or zeroed upper field. Further stimulus writes all ones to the status offset and to the masks, so that a writable status or a mask wider than 22 bits appears in the read data. A long random phase compares both interrupt lines every clock against a behavioural model, which exposes swapped masks or a line that ignores level bits.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    parameter int EVT_N  = 11;
    parameter int LVL_N  = 11;
    parameter int STAT_W = EVT_N + LVL_N;
    parameter int DATA_W = 32;
    parameter int ADDR_W = 8;
    parameter int NUM_LINES = 2;

    parameter logic [ADDR_W-1:0] OFS_STATUS    = 8'h34;
    parameter logic [ADDR_W-1:0] OFS_CLEAR     = 8'h38;
    parameter logic [ADDR_W-1:0] OFS_MASK_MAIN = 8'h3C;
    parameter logic [ADDR_W-1:0] OFS_MASK_AUX  = 8'h40;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_CLEAR,
        SEL_MASK_MAIN,
        SEL_MASK_AUX
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_STATUS:    return SEL_STATUS;
            OFS_CLEAR:     return SEL_CLEAR;
            OFS_MASK_MAIN: return SEL_MASK_MAIN;
            OFS_MASK_AUX:  return SEL_MASK_AUX;
            default:       return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/sirq_sticky_bank.sv
module sirq_sticky_bank #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    typedef struct packed {
        logic [N-1:0] bits;
    } sticky_t;

    sticky_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set is applied after clear so a colliding set survives
        st_d.bits = (st_q.bits & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.bits;

    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

    p_set_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & clr_i)) |=> ((q_o & $past(set_i & clr_i)) == $past(set_i & clr_i)));

    p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0));

    p_untouched_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q_o & $past(~set_i & ~clr_i)) == ($past(q_o) & $past(~set_i & ~clr_i))));
endmodule

// File: rtl/sirq_mask_reg.sv
module sirq_mask_reg #(
    parameter int                 W      = 22,
    parameter int                 DW     = 32,
    parameter int                 AW     = 8,
    parameter logic [AW-1:0]      OFS    = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [W-1:0]  q_o
);
    typedef struct packed {
        logic [W-1:0] mask;
    } mask_t;

    mask_t m_d, m_q;
    logic  hit;

    assign hit = wr_i && (addr_i == OFS);

    always_comb begin
        m_d = m_q;
        if (hit) m_d.mask = wdata_i[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign q_o = m_q.mask;

    p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS) |=> (q_o == $past(wdata_i[W-1:0])));

    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == OFS) |=> $stable(q_o));
endmodule

// File: rtl/sirq_line_reduce.sv
module sirq_line_reduce #(
    parameter int W = 22
) (
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    logic [W-1:0] hits;
    assign hits  = status_i & mask_i;
    assign irq_o = |hits;
endmodule

// File: rtl/sirq_status_ctrl.sv
module sirq_status_ctrl
    import sirq_pkg::*;
#(
    parameter int N_EVT = EVT_N,
    parameter int N_LVL = LVL_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_EVT-1:0]  evt_set_i,
    input  logic [N_LVL-1:0]  lvl_i,
    output logic              irq_main_o,
    output logic              irq_aux_o
);
    localparam int SW = N_EVT + N_LVL;

    reg_sel_e         sel;
    logic [N_EVT-1:0] clr_vec;
    logic [N_EVT-1:0] evt_q;
    logic [SW-1:0]    status;
    logic [SW-1:0]    mask_q [NUM_LINES];
    logic [NUM_LINES-1:0] irq;

    assign sel     = decode_sel(reg_addr);
    assign clr_vec = (reg_wr && sel == SEL_CLEAR) ? reg_wdata[N_EVT-1:0] : '0;

    sirq_sticky_bank #(.N(N_EVT)) i_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_set_i),
        .clr_i (clr_vec),
        .q_o   (evt_q)
    );

    assign status = {lvl_i, evt_q};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam logic [ADDR_W-1:0] LINE_OFS = (g == 0) ? OFS_MASK_MAIN : OFS_MASK_AUX;

        sirq_mask_reg #(
            .W   (SW),
            .DW  (DATA_W),
            .AW  (ADDR_W),
            .OFS (LINE_OFS)
        ) i_mask (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (reg_wr),
            .addr_i  (reg_addr),
            .wdata_i (reg_wdata),
            .q_o     (mask_q[g])
        );

        sirq_line_reduce #(.W(SW)) i_reduce (
            .status_i (status),
            .mask_i   (mask_q[g]),
            .irq_o    (irq[g])
        );
    end

    assign irq_main_o = irq[0];
    assign irq_aux_o  = irq[1];

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_STATUS:    reg_rdata[SW-1:0] = status;
            SEL_MASK_MAIN: reg_rdata[SW-1:0] = mask_q[0];
            SEL_MASK_AUX:  reg_rdata[SW-1:0] = mask_q[1];
            default:       reg_rdata = '0;
        endcase
    end

    p_main_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[0] == '0) |-> !irq_main_o);

    p_aux_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[1] == '0) |-> !irq_aux_o);

    p_level_ignores_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_STATUS) |-> (reg_rdata[SW-1:N_EVT] == lvl_i));

    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:SW] == '0);
endmodule

// File: tb/test_sirq_status_ctrl.sv
module test_sirq_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h34;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [10:0] evt_set_i = '0;
    logic [10:0] lvl_i = '0;
    logic        irq_main_o, irq_aux_o;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit done = 0;

    always #5 clk = ~clk;

    sirq_status_ctrl i_sirq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set_i(evt_set_i),
        .lvl_i(lvl_i), .irq_main_o(irq_main_o), .irq_aux_o(irq_aux_o)
    );

    // behavioural reference
    bit [10:0] m_evt;
    bit [21:0] m_mask [2];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_evt = '0; m_mask[0] = '0; m_mask[1] = '0;
        end else begin
            bit [10:0] clr;
            clr = '0;
            if (reg_wr) begin
                if (reg_addr == 8'h38) clr = reg_wdata[10:0];
                if (reg_addr == 8'h3C) m_mask[0] = reg_wdata[21:0];
                if (reg_addr == 8'h40) m_mask[1] = reg_wdata[21:0];
            end
            m_evt = (m_evt & ~clr) | evt_set_i;
        end
    end

    function automatic bit [31:0] exp_rd(input bit [7:0] a);
        case (a)
            8'h34:   return {10'b0, lvl_i, m_evt};
            8'h3C:   return {10'b0, m_mask[0]};
            8'h40:   return {10'b0, m_mask[1]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input bit [31:0] act, input bit [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit [21:0] st;
            st = {lvl_i, m_evt};
            chk(cur_req, "rdata", reg_rdata, exp_rd(reg_addr));
            chk("R7", "irq_main", {31'b0, irq_main_o}, {31'b0, |(st & m_mask[0])});
            chk("R7", "irq_aux", {31'b0, irq_aux_o}, {31'b0, |(st & m_mask[1])});
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic neg_chk(input string req, input string what, input bit [31:0] act_sel, input bit [31:0] exp);
        @(negedge clk);
        chk(req, what, act_sel, exp);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        cur_req = "R1";
        reg_addr = 8'h34;
        @(negedge clk); chk("R1", "status after reset", reg_rdata, 32'h0);
        chk("R1", "irq after reset", {30'b0, irq_main_o, irq_aux_o}, 32'h0);
        cyc(); reg_addr = 8'h3C;
        @(negedge clk); chk("R1", "main mask after reset", reg_rdata, 32'h0);

        // R2 pulse sets and sticks
        cur_req = "R2";
        cyc(); reg_addr = 8'h34;
        evt_set_i = 11'h008; cyc(); evt_set_i = '0;
        @(negedge clk); chk("R2", "bit3 set", reg_rdata, 32'h8);
        repeat (3) cyc();
        @(negedge clk); chk("R2", "bit3 sticky", reg_rdata, 32'h8);
        for (int k = 0; k < 11; k++) begin
            evt_set_i = 11'(1) << k; cyc(); evt_set_i = '0;
        end
        @(negedge clk); chk("R2", "all events", reg_rdata, 32'h7FF);

        // R3 partial clear
        cur_req = "R3";
        wr(8'h38, 32'h0000_0505);
        reg_addr = 8'h34;
        @(negedge clk); chk("R3", "partial clear", reg_rdata, 32'h2FA);
        wr(8'h38, 32'hFFFF_FFFF); reg_addr = 8'h34;
        @(negedge clk); chk("R3", "full clear", reg_rdata, 32'h0);

        // R4 collision
        cur_req = "R4";
        evt_set_i = 11'h004; reg_wr = 1'b1; reg_addr = 8'h38; reg_wdata = 32'h004;
        cyc(); evt_set_i = '0; reg_wr = 1'b0; reg_addr = 8'h34;
        @(negedge clk); chk("R4", "set wins", reg_rdata, 32'h4);
        evt_set_i = 11'h400; reg_wr = 1'b1; reg_addr = 8'h38; reg_wdata = 32'h7FF;
        cyc(); evt_set_i = '0; reg_wr = 1'b0; reg_addr = 8'h34;
        @(negedge clk); chk("R4", "set wins over full clear", reg_rdata, 32'h400);

        // R5 live level bits
        cur_req = "R5";
        wr(8'h38, 32'h7FF);
        lvl_i = 11'h5A5; reg_addr = 8'h34;
        @(negedge clk); chk("R5", "level same cycle", reg_rdata, 32'h5A5 << 11);
        cyc();
        wr(8'h38, 32'hFFFF_FFFF); reg_addr = 8'h34;
        @(negedge clk); chk("R5", "level after clear write", reg_rdata, 32'h5A5 << 11);
        cyc(); lvl_i = '0;
        @(negedge clk); chk("R5", "level drops", reg_rdata, 32'h0);

        // R6 masks
        cur_req = "R6";
        cyc();
        wr(8'h3C, 32'hFFFF_FFFF); reg_addr = 8'h3C;
        @(negedge clk); chk("R6", "main mask width", reg_rdata, 32'h003F_FFFF);
        cyc();
        wr(8'h40, 32'h0001_2345); reg_addr = 8'h40;
        @(negedge clk); chk("R6", "aux mask value", reg_rdata, 32'h0001_2345);
        cyc(); reg_addr = 8'h3C;
        @(negedge clk); chk("R6", "main mask kept", reg_rdata, 32'h003F_FFFF);

        // R7 line routing
        cur_req = "R7";
        cyc();
        wr(8'h3C, 32'h0000_0001);
        wr(8'h40, 32'h0000_4000);
        lvl_i = 11'h008;
        @(negedge clk); chk("R7", "aux on tx half empty", {30'b0, irq_main_o, irq_aux_o}, 32'h1);
        cyc(); lvl_i = '0; evt_set_i = 11'h001; cyc(); evt_set_i = '0;
        @(negedge clk); chk("R7", "main on cmd crc", {30'b0, irq_main_o, irq_aux_o}, 32'h2);
        wr(8'h38, 32'h1);
        @(negedge clk); chk("R7", "lines idle", {30'b0, irq_main_o, irq_aux_o}, 32'h0);

        // R8 read-only / unmapped
        cur_req = "R8";
        cyc();
        wr(8'h34, 32'hFFFF_FFFF); reg_addr = 8'h34;
        @(negedge clk); chk("R8", "status unwritable", reg_rdata, 32'h0);
        cyc(); evt_set_i = 11'h020; cyc(); evt_set_i = '0; reg_addr = 8'h38;
        @(negedge clk); chk("R8", "clear reads zero", reg_rdata, 32'h0);
        cyc(); reg_addr = 8'h10;
        @(negedge clk); chk("R8", "unmapped reads zero", reg_rdata, 32'h0);

        // random phase against the model
        cur_req = "R7";
        for (int i = 0; i < 600; i++) begin
            int r;
            cyc();
            r = $urandom_range(0, 9);
            evt_set_i = ($urandom_range(0, 3) == 0) ? 11'($urandom) : '0;
            lvl_i = 11'($urandom);
            reg_wr = (r < 4);
            case ($urandom_range(0, 4))
                0: reg_addr = 8'h34;
                1: reg_addr = 8'h38;
                2: reg_addr = 8'h3C;
                3: reg_addr = 8'h40;
                default: reg_addr = 8'h44;
            endcase
            reg_wdata = $urandom;
        end
        cyc(); reg_wr = 1'b0;
        @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule